// File: doc/BRIEF.md
# Burst Address Generator with Linear and Interleaved Wrap

This block produces the word address for a four-beat burst into a synchronous burst memory. A burst begins when one of two active-low start strobes captures an external address. After that, each cycle with the advance strobe low steps the two low address bits to the next beat. A cycle with the advance strobe high is a wait state, and the address is held. The upper address bits never change inside a burst. The low bits wrap within the aligned four-word block.

A static select input chooses the stepping order:
- **Linear order** adds one modulo four.
- **Interleaved order** XORs the starting offset with a two-bit beat count, which gives the ordering that cache-line fills expect.

The two start strobes behave differently:
- **Processor-side strobe** is honoured only while the primary enable is low.
- **Controller-side strobe** loads the address whatever the enable is doing.

If both strobes load in the same cycle, the result is the same, since both take the external address. The block drives out the full current address and the beat number within the burst.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is low, and on the first sample after it, `addr_out` is all zeros and `beat_out` is 0.
- R2: A clock edge with `adsc_n` low loads `addr_in` into `addr_out` and clears `beat_out` to 0, whatever the level of `en_n`.
- R3: A clock edge with `adsp_n` low and `en_n` low loads `addr_in` into `addr_out` and clears `beat_out` to 0.
- R4: With `en_n` high, a low `adsp_n` is ignored. If `adsc_n` is also high, the edge behaves as an advance or a hold, as set by `adv_n`.
- R5: On an edge with no load and `adv_n` low, when `ilv` is 0 (linear), `addr_out[1:0]` becomes its previous value plus one, modulo 4. For example, a start at 3 gives 3, 0, 1, 2.
- R6: On an edge with no load and `adv_n` low, when `ilv` is 1 (interleaved), `addr_out[1:0]` becomes the burst's start offset XOR the new `beat_out`. For example, a start at 1 gives 1, 0, 3, 2, and a start at 3 gives 3, 2, 1, 0.
- R7: On an edge with no load and `adv_n` high, `addr_out` and `beat_out` stay unchanged.
- R8: On an edge with no load, `addr_out` bits above bit 1 stay unchanged. No carry leaves the two low bits.
- R9: On every advance, `beat_out` increments modulo 4. After the fourth beat it wraps to 0 within the same block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | AW | External start address |
| adsp_n | input | 1 | Processor-side start strobe, active low, gated by `en_n` |
| adsc_n | input | 1 | Controller-side start strobe, active low, never gated |
| adv_n | input | 1 | Advance strobe, active low; high means a wait state |
| en_n | input | 1 | Primary enable, active low; when high it masks `adsp_n` |
| ilv | input | 1 | Order select: 1 = interleaved, 0 = linear |
| addr_out | output | AW | Current burst address |
| beat_out | output | 2 | Beat index within the burst |

## Verification
Both outputs are registered. A load, an advance or a hold is therefore visible exactly one rising edge after the inputs that caused it, and never in the same cycle.

The bench changes inputs only at falling edges. It updates its own reference model right after each rising edge, using the inputs that were held across that edge. It compares both outputs at the following falling edge, which falls inside the one-edge window where the result must appear.

Directed bursts cover the wrap sequences in both orders, the masked processor strobe, and wait states. Constrained-random traffic then mixes all strobes and both orders.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_in,
  input  logic          adsp_n,
  input  logic          adsc_n,
  input  logic          adv_n,
  input  logic          en_n,
  input  logic          ilv,
  output logic [AW-1:0] addr_out,
  output logic [1:0]    beat_out
);
  localparam int UW = AW - 2;

  logic [UW-1:0] hi_q;
  logic [1:0]    lo_q, start_q, beat_q;
  logic          live_q;

  wire       load_c  = !adsc_n || (!adsp_n && !en_n);
  wire       step_c  = !load_c && !adv_n;
  wire [1:0] beat_nx = beat_q + 2'd1;
  wire [1:0] lo_nx   = ilv ? (start_q ^ beat_nx) : (lo_q + 2'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      lo_q    <= '0;
      start_q <= '0;
      beat_q  <= '0;
      live_q  <= 1'b0;
    end else begin
      live_q <= 1'b1;
      if (load_c) begin
        hi_q    <= addr_in[AW-1:2];
        lo_q    <= addr_in[1:0];
        start_q <= addr_in[1:0];
        beat_q  <= 2'd0;
      end else if (step_c) begin
        lo_q   <= lo_nx;
        beat_q <= beat_nx;
      end
    end
  end

  assign addr_out = {hi_q, lo_q};
  assign beat_out = beat_q;

  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && $past(!adsc_n) |-> (addr_out == $past(addr_in)) && (beat_out == 2'd0)); // R2
  AST_PROC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && $past(!adsp_n && !en_n) |-> (addr_out == $past(addr_in)) && (beat_out == 2'd0)); // R3
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && $past(adsc_n && (adsp_n || en_n) && adv_n) |-> $stable(addr_out) && $stable(beat_out)); // R7
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && $past(!load_c) |-> addr_out[AW-1:2] == $past(addr_out[AW-1:2])); // R8
  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && $past(step_c && !ilv) |-> addr_out[1:0] == $past(addr_out[1:0]) + 2'd1); // R5
  AST_ILV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && $past(step_c && ilv) |-> addr_out[1:0] == ($past(start_q) ^ beat_out)); // R6
  AST_BEAT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && $past(step_c) |-> beat_out == $past(beat_out) + 2'd1); // R9
endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
  localparam int AW = 18;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1, en_n = 1'b1, ilv = 1'b0;
  logic [AW-1:0] addr_out;
  logic [1:0]    beat_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [AW-1:0] m_addr = '0;
  logic [1:0]    m_start = '0, m_beat = '0;

  burst_addr_gen #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .adv_n(adv_n), .en_n(en_n), .ilv(ilv), .addr_out(addr_out), .beat_out(beat_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [1:0] next_lo(input logic il, input logic [1:0] cur,
                                         input logic [1:0] st, input logic [1:0] bt);
    return il ? (st ^ (bt + 2'd1)) : (cur + 2'd1);
  endfunction

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycle(input string req);
    @(posedge clk);
    if (!adsc_n || (!adsp_n && !en_n)) begin
      m_addr = addr_in; m_start = addr_in[1:0]; m_beat = 2'd0;
    end else if (!adv_n) begin
      m_addr[1:0] = next_lo(ilv, m_addr[1:0], m_start, m_beat);
      m_beat = m_beat + 2'd1;
    end
    @(negedge clk);
    check(req, addr_out, m_addr);
    check(req, {{(AW-2){1'b0}}, beat_out}, {{(AW-2){1'b0}}, m_beat});
  endtask

  task automatic drive(input logic sp, input logic sc, input logic av, input logic en,
                       input logic il, input logic [AW-1:0] a);
    adsp_n = sp; adsc_n = sc; adv_n = av; en_n = en; ilv = il; addr_in = a;
  endtask

  initial begin
    repeat (50 * 4000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    @(negedge clk);
    check("R1 reset addr", addr_out, '0);
    check("R1 reset beat", {{(AW-2){1'b0}}, beat_out}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", addr_out, '0);

    // R5 linear from offset 3, with wrap and no carry (R8)
    drive(1, 0, 1, 1, 0, 18'h2_ABC7);
    cycle("R2 ctrl load with en_n high");
    check("R2 loaded value", addr_out, 18'h2_ABC7);
    drive(1, 1, 0, 0, 0, 18'h0_0000);
    for (int i = 0; i < 4; i++) cycle("R5 R8 R9 linear step");
    check("R9 wrap back to start", addr_out, 18'h2_ABC7);

    // R6 interleaved from offset 1 and 3, via processor strobe (R3)
    drive(0, 1, 1, 0, 1, 18'h1_0005);
    cycle("R3 proc load");
    check("R3 loaded value", addr_out, 18'h1_0005);
    drive(1, 1, 0, 0, 1, '0);
    cycle("R6 ilv beat1");
    check("R6 ilv 1->0", addr_out, 18'h1_0004);
    cycle("R6 ilv beat2");
    check("R6 ilv ->3", addr_out, 18'h1_0007);
    drive(1, 1, 1, 0, 1, '0);
    cycle("R7 wait state");
    check("R7 hold", addr_out, 18'h1_0007);
    drive(1, 1, 0, 0, 1, '0);
    cycle("R6 ilv beat3");
    check("R6 ilv ->2", addr_out, 18'h1_0006);
    drive(1, 0, 1, 0, 1, 18'h0_0013);
    cycle("R2 ctrl load");
    drive(1, 1, 0, 0, 1, '0);
    for (int i = 0; i < 3; i++) cycle("R6 ilv from 3");
    check("R6 ilv 3 ends at 0", addr_out, 18'h0_0010);

    // R4 masked processor strobe: advance, then hold
    drive(0, 1, 0, 1, 0, 18'h3_FFFF);
    cycle("R4 masked proc strobe advance");
    check("R4 not loaded", addr_out, 18'h0_0011);
    drive(0, 1, 1, 1, 0, 18'h3_FFFF);
    cycle("R4 masked proc strobe hold");
    check("R4 held", addr_out, 18'h0_0011);

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      drive(r[3:0] != 0, r[7:4] != 0, 1'($urandom_range(0, 3) == 0),
            1'($urandom), (i / 200) % 2 == 1, AW'($urandom));
      cycle("R2 R3 R4 R5 R6 R7 R9 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule